// File: doc/BRIEF.md
# Single-Precision Floating-Point Add/Compare Unit

This unit is an arithmetic coprocessor slice for 32-bit floating-point values in the standard binary32 layout. Bit 31 is the sign, bits 30:23 hold the biased exponent and bits 22:0 hold the fraction. Each cycle it can take one operation, qualified by a valid strobe: addition, subtraction or three-way comparison of two operands. After a fixed number of cycles set at compile time, it returns either a 32-bit sum or difference, or a set of compare flags.

The unit is kept small by leaving out special values. There are no NaNs, no infinities and no subnormals. An operand whose exponent field is zero counts as zero. All-ones exponents are treated as ordinary large numbers. A result too small to be normal is flushed to zero, and a result too large saturates to the largest finite magnitude. Rounding always uses round-to-nearest, ties-to-even, and there is no mode input.

The latency parameter takes values from 1 to 9. A larger value adds register stages behind the arithmetic, so that retiming can spread that logic and raise the clock rate. The number of results and their order do not change.

Top module: `fp_addcmp_unit`

## Requirements
- R1: For normal operands, op_code 2'b00 returns the binary32 sum. The sign is in bit 31, the exponent in bits 30:23 and the fraction in bits 22:0. Mixed signs give a magnitude difference, and the result is renormalised after cancellation.
- R2: op_code 2'b01 returns opnd_a minus opnd_b, computed as an addition with the sign bit of opnd_b inverted. op_code 2'b10 and 2'b11 both select compare.
- R3: If the rounded exponent reaches 255, the add/sub result saturates to the largest finite magnitude (exponent 8'hFE, fraction all ones) and keeps its sign. An add/sub result never carries exponent field 8'hFF.
- R4: An operand with exponent field 0 is taken as zero. A result whose normalised exponent falls below 1 is flushed to +0. A result with exponent field 0 always has a zero fraction.
- R5: A sum or difference that is exactly zero is returned as +0 (32'h0000_0000), including when both operands are negative zero.
- R6: Rounding is round-to-nearest, ties-to-even, based on guard, round and sticky bits kept through alignment. A round-up that carries out of the fraction increments the exponent.
- R7: A compare returns exactly one of cmp_eq, cmp_lt and cmp_gt for opnd_a against opnd_b, and +0 equals −0. During a compare, res_data is 0. During an add or sub, all three flags are 0.
- R8: res_valid is high exactly LATENCY cycles after the cycle in which op_valid was sampled high. A new operation can be issued every cycle, and results leave in issue order.
- R9: During and after reset, res_valid is low and res_data and the flags are 0. Whenever res_valid is low, res_data and the flags stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 2 | 00 add, 01 subtract, 1x compare |
| opnd_a | input | 32 | First operand, binary32 |
| opnd_b | input | 32 | Second operand, binary32 |
| res_valid | output | 1 | Result present this cycle |
| res_data | output | 32 | Sum or difference, binary32; 0 on compare |
| cmp_eq | output | 1 | opnd_a equals opnd_b |
| cmp_lt | output | 1 | opnd_a is less than opnd_b |
| cmp_gt | output | 1 | opnd_a is greater than opnd_b |

## Verification
Every result, whether a sum, a difference or a set of flags, appears exactly LATENCY rising edges after the edge that samples the operation. There is no path that is faster or slower than the others. The directed tasks drive an operation on a falling edge and drop op_valid on the next falling edge. They then wait LATENCY − 1 more falling edges and sample there, so exactly LATENCY rising edges lie between stimulus and check. The streaming task issues back-to-back operations with gaps and compares res_valid and res_data on every falling edge against the operation issued LATENCY cycles earlier, which checks timing and ordering together.

// File: rtl/fp_addcmp_pkg.sv
package fp_addcmp_pkg;

  typedef enum logic [1:0] {
    FOP_ADD  = 2'b00,
    FOP_SUB  = 2'b01,
    FOP_CMP  = 2'b10,
    FOP_CMP2 = 2'b11
  } fop_e;

  typedef struct packed {
    logic        vld;
    logic        is_cmp;
    logic [31:0] data;
    logic        eq;
    logic        lt;
    logic        gt;
  } fp_beat_t;

  localparam logic [31:0] FP_MAX_POS = 32'h7F7F_FFFF;

  // Sum of two binary32 values; exponent 0 reads as zero, RNE, flush, saturate.
  function automatic logic [31:0] fp_add(input logic [31:0] a, input logic [31:0] b);
    logic [31:0]       x, y;
    logic [7:0]        ex, ey, d;
    logic [23:0]       mx, my;
    logic [26:0]       xe, ye, ys, n;
    logic              stk, up;
    logic [27:0]       s;
    logic signed [9:0] e;
    logic [24:0]       r;
    int                pos;
    if (a[30:0] >= b[30:0]) begin x = a; y = b; end
    else begin x = b; y = a; end
    ex = x[30:23];
    ey = y[30:23];
    mx = (ex == 8'd0) ? 24'd0 : {1'b1, x[22:0]};
    my = (ey == 8'd0) ? 24'd0 : {1'b1, y[22:0]};
    d  = ex - ey;
    xe = {mx, 3'b000};
    ye = {my, 3'b000};
    if (d >= 8'd27) begin
      ys = {26'd0, |my};
    end else begin
      ys    = ye >> d;
      stk   = |(ye & ((27'd1 << d) - 27'd1));
      ys[0] = ys[0] | stk;
    end
    if (x[31] == y[31]) s = {1'b0, xe} + {1'b0, ys};
    else                s = {1'b0, xe} - {1'b0, ys};
    if (s == 28'd0) return 32'd0;
    e = {2'b00, ex};
    if (s[27]) begin
      n = {s[27:2], s[1] | s[0]};
      e = e + 10'sd1;
    end else begin
      pos = 0;
      for (int i = 0; i < 27; i++) if (s[i]) pos = i;
      n = s[26:0] << (26 - pos);
      e = e - 10'(26 - pos);
    end
    if (e < 10'sd1) return 32'd0;
    up = n[2] & (n[1] | n[0] | n[3]);
    r  = {1'b0, n[26:3]} + {24'd0, up};
    if (r[24]) begin
      r = r >> 1;
      e = e + 10'sd1;
    end
    if (e >= 10'sd255) return {x[31], FP_MAX_POS[30:0]};
    return {x[31], e[7:0], r[22:0]};
  endfunction

  // Three-way compare, returns {eq, lt, gt}; zero exponent reads as zero.
  function automatic logic [2:0] fp_cmp(input logic [31:0] a, input logic [31:0] b);
    logic [30:0] ma, mb;
    logic        eq, lt;
    ma = (a[30:23] == 8'd0) ? 31'd0 : a[30:0];
    mb = (b[30:23] == 8'd0) ? 31'd0 : b[30:0];
    eq = (ma == mb) && ((a[31] == b[31]) || (ma == 31'd0));
    if (eq)                lt = 1'b0;
    else if (a[31] != b[31]) lt = a[31];
    else if (a[31])        lt = (ma > mb);
    else                   lt = (ma < mb);
    return {eq, lt, ~eq & ~lt};
  endfunction

endpackage

// File: rtl/fp_add_core.sv
module fp_add_core
  import fp_addcmp_pkg::*;
(
  input  logic [31:0] lhs,
  input  logic [31:0] rhs,
  input  logic        negate_rhs,
  output logic [31:0] sum
);
  logic [31:0] rhs_eff;
  assign rhs_eff = {rhs[31] ^ negate_rhs, rhs[30:0]};
  assign sum     = fp_add(lhs, rhs_eff);
endmodule

// File: rtl/fp_cmp_core.sv
module fp_cmp_core
  import fp_addcmp_pkg::*;
(
  input  logic [31:0] lhs,
  input  logic [31:0] rhs,
  output logic        is_eq,
  output logic        is_lt,
  output logic        is_gt
);
  assign {is_eq, is_lt, is_gt} = fp_cmp(lhs, rhs);
endmodule

// File: rtl/fp_delay_line.sv
module fp_delay_line #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [DEPTH-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[DEPTH-1];
endmodule

// File: rtl/fp_addcmp_unit.sv
module fp_addcmp_unit
  import fp_addcmp_pkg::*;
#(
  parameter int LATENCY = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [1:0]  op_code,
  input  logic [31:0] opnd_a,
  input  logic [31:0] opnd_b,
  output logic        res_valid,
  output logic [31:0] res_data,
  output logic        cmp_eq,
  output logic        cmp_lt,
  output logic        cmp_gt
);
  localparam int BEAT_W = $bits(fp_beat_t);

  logic        in_is_cmp;
  logic [31:0] add_sum;
  logic        c_eq, c_lt, c_gt;
  fp_beat_t    beat_in, beat_out;
  logic        out_is_cmp;

  assign in_is_cmp = op_code[1];

  fp_add_core u_add (
    .lhs        (opnd_a),
    .rhs        (opnd_b),
    .negate_rhs (op_code[0]),
    .sum        (add_sum)
  );

  fp_cmp_core u_cmp (
    .lhs   (opnd_a),
    .rhs   (opnd_b),
    .is_eq (c_eq),
    .is_lt (c_lt),
    .is_gt (c_gt)
  );

  always_comb begin
    beat_in = '0;
    if (op_valid) begin
      beat_in.vld    = 1'b1;
      beat_in.is_cmp = in_is_cmp;
      if (in_is_cmp) begin
        beat_in.eq = c_eq;
        beat_in.lt = c_lt;
        beat_in.gt = c_gt;
      end else begin
        beat_in.data = add_sum;
      end
    end
  end

  fp_delay_line #(.W(BEAT_W), .DEPTH(LATENCY)) u_pipe (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (beat_in),
    .dout  (beat_out)
  );

  assign out_is_cmp = beat_out.is_cmp;
  assign res_valid  = beat_out.vld;
  assign res_data   = beat_out.data;
  assign cmp_eq     = beat_out.eq;
  assign cmp_lt     = beat_out.lt;
  assign cmp_gt     = beat_out.gt;
endmodule

// File: rtl/fp_addcmp_checker.sv
module fp_addcmp_checker #(
  parameter int LATENCY = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic        res_valid,
  input logic [31:0] res_data,
  input logic        cmp_eq,
  input logic        cmp_lt,
  input logic        cmp_gt,
  input logic        out_is_cmp
);
  logic [3:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  since_rst <= '0;
    else if (since_rst != 4'hF)  since_rst <= since_rst + 4'd1;
  end

  // R8
  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(since_rst) >= LATENCY) |-> (res_valid == $past(op_valid, LATENCY)));

  // R7
  p_one_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && out_is_cmp) |-> ($countones({cmp_eq, cmp_lt, cmp_gt}) == 1 && res_data == 32'd0));

  // R7
  p_no_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !out_is_cmp) |-> ({cmp_eq, cmp_lt, cmp_gt} == 3'b000));

  // R3
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !out_is_cmp) |-> (res_data[30:23] != 8'hFF));

  // R4
  p_no_subnormal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !out_is_cmp && res_data[30:23] == 8'd0) |-> (res_data[22:0] == 23'd0));

  // R5
  p_pos_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !out_is_cmp && res_data[30:0] == 31'd0) |-> !res_data[31]);

  // R9
  p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (res_data == 32'd0 && {cmp_eq, cmp_lt, cmp_gt} == 3'b000));
endmodule

bind fp_addcmp_unit fp_addcmp_checker #(.LATENCY(LATENCY)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid   (op_valid),
  .res_valid  (res_valid),
  .res_data   (res_data),
  .cmp_eq     (cmp_eq),
  .cmp_lt     (cmp_lt),
  .cmp_gt     (cmp_gt),
  .out_is_cmp (out_is_cmp)
);

// File: tb/fp_addcmp_unit_test.sv
module fp_addcmp_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 3;
  localparam int NSTREAM    = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_code = 2'b00;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic        res_valid;
  logic [31:0] res_data;
  logic        cmp_eq, cmp_lt, cmp_gt;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_addcmp_unit #(.LATENCY(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .res_valid(res_valid),
    .res_data(res_data), .cmp_eq(cmp_eq), .cmp_lt(cmp_lt), .cmp_gt(cmp_gt)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  // Drive one op, sample exactly LAT rising edges later.
  task automatic run_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                        output logic v, output logic [31:0] r, output logic [2:0] f);
    @(negedge clk);
    op_valid = 1'b1; op_code = op; opnd_a = a; opnd_b = b;
    @(negedge clk);
    op_valid = 1'b0;
    repeat (LAT-1) @(negedge clk);
    v = res_valid; r = res_data; f = {cmp_eq, cmp_lt, cmp_gt};
  endtask

  task automatic arith(input string tag, input logic [1:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] exp);
    logic v; logic [31:0] r; logic [2:0] f;
    run_op(op, a, b, v, r, f);
    chk({tag, " data"}, 64'(r), 64'(exp));
    chk({tag, " valid/flags R7"}, 64'({v, f}), 64'({1'b1, 3'b000}));
  endtask

  task automatic cmp(input string tag, input logic [31:0] a, input logic [31:0] b,
                     input logic [2:0] exp);
    logic v; logic [31:0] r; logic [2:0] f;
    run_op(2'b10, a, b, v, r, f);
    chk({tag, " flags eq/lt/gt"}, 64'(f), 64'(exp));
    chk({tag, " valid/data R7"}, 64'({v, r}), 64'({1'b1, 32'd0}));
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R9 reset outputs", 64'({res_valid, res_data, cmp_eq, cmp_lt, cmp_gt}), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 idle outputs", 64'({res_valid, res_data, cmp_eq, cmp_lt, cmp_gt}), 64'd0);
  endtask

  task automatic t_basic;
    arith("R1 1+1", 2'b00, 32'h3F80_0000, 32'h3F80_0000, 32'h4000_0000);
    arith("R1 1.5+2.25", 2'b00, 32'h3FC0_0000, 32'h4010_0000, 32'h4070_0000);
    arith("R1 cancel 1+ulp-1", 2'b01, 32'h3F80_0001, 32'h3F80_0000, 32'h3400_0000);
    arith("R2 1-3", 2'b01, 32'h3F80_0000, 32'h4040_0000, 32'hC000_0000);
    arith("R2 sub neg operand", 2'b01, 32'h3F80_0000, 32'hBF80_0000, 32'h4000_0000);
    arith("R5 -1-(-1)", 2'b01, 32'hBF80_0000, 32'hBF80_0000, 32'h0000_0000);
    arith("R5 -0+-0", 2'b00, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000);
  endtask

  task automatic t_round;
    arith("R6 tie to even down", 2'b00, 32'h3F80_0000, 32'h3380_0000, 32'h3F80_0000);
    arith("R6 tie to even up", 2'b00, 32'h3F80_0001, 32'h3380_0000, 32'h3F80_0002);
    arith("R6 sticky above half", 2'b00, 32'h3F80_0000, 32'h3380_0001, 32'h3F80_0001);
    arith("R6 far shift sticky only", 2'b00, 32'h3F80_0000, 32'h3080_0000, 32'h3F80_0000);
    arith("R6 round carry to exp", 2'b00, 32'h3FFF_FFFF, 32'h3380_0000, 32'h4000_0000);
  endtask

  task automatic t_limits;
    arith("R3 pos saturate", 2'b00, 32'h7F7F_FFFF, 32'h7F7F_FFFF, 32'h7F7F_FFFF);
    arith("R3 neg saturate", 2'b00, 32'hFF7F_FFFF, 32'hFF7F_FFFF, 32'hFF7F_FFFF);
    arith("R4 underflow flush", 2'b01, 32'h00C0_0000, 32'h0080_0000, 32'h0000_0000);
    arith("R4 subnormal input as zero", 2'b00, 32'h0000_0001, 32'h3F80_0000, 32'h3F80_0000);
    arith("R4 zero plus value", 2'b00, 32'h0000_0000, 32'h4040_0000, 32'h4040_0000);
  endtask

  task automatic t_compare;
    cmp("R7 1<2", 32'h3F80_0000, 32'h4000_0000, 3'b010);
    cmp("R7 2>1", 32'h4000_0000, 32'h3F80_0000, 3'b001);
    cmp("R7 -1<1", 32'hBF80_0000, 32'h3F80_0000, 3'b010);
    cmp("R7 -2<-1", 32'hC000_0000, 32'hBF80_0000, 3'b010);
    cmp("R7 +0==-0", 32'h0000_0000, 32'h8000_0000, 3'b100);
    cmp("R7 x==x", 32'h4049_0FDB, 32'h4049_0FDB, 3'b100);
    begin
      logic v; logic [31:0] r; logic [2:0] f;
      run_op(2'b11, 32'h0000_0000, 32'h3F80_0000, v, r, f);
      chk("R2 opcode 11 compares", 64'({v, r, f}), 64'({1'b1, 32'd0, 3'b010}));
    end
  endtask

  // Back-to-back stream with gaps; 2^i op 2^i gives 2^(i+1).
  task automatic t_stream;
    for (int cyc = 0; cyc <= NSTREAM + LAT; cyc++) begin
      @(negedge clk);
      begin
        int  k;
        logic ev;
        k  = cyc - LAT;
        ev = (k >= 0) && (k < NSTREAM) && ((k % 3) != 2);
        chk($sformatf("R8 valid at cycle %0d", cyc), 64'(res_valid), 64'(ev));
        if (ev)
          chk($sformatf("R8 ordered data op %0d", k), 64'(res_data),
              64'({1'b0, 8'(128 + k), 23'd0}));
      end
      if (cyc < NSTREAM && (cyc % 3) != 2) begin
        op_valid = 1'b1;
        op_code  = (cyc % 2 == 1) ? 2'b01 : 2'b00;
        opnd_a   = {1'b0, 8'(127 + cyc), 23'd0};
        opnd_b   = {(cyc % 2 == 1), 8'(127 + cyc), 23'd0};
      end else begin
        op_valid = 1'b0;
      end
    end
    op_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_round();
    t_limits();
    t_compare();
    t_stream();
    repeat (LAT + 1) @(negedge clk);
    chk("R9 drained outputs", 64'({res_valid, res_data, cmp_eq, cmp_lt, cmp_gt}), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule